// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves incoming frames into host buffers. The host describes the buffers in a circular ring of descriptors in memory, and each descriptor has an ownership flag. The engine visits the descriptors one at a time, strictly in ring order. It fills a buffer only when the descriptor's ownership flag says the buffer belongs to the engine. When a frame is done, or when the buffer runs out of room, it writes back a status word and returns the descriptor to the host. A frame longer than one buffer continues in the next descriptor, so one frame can span a chain of several buffers.

Descriptors are read and written over a word-wide memory port with one request channel and one response channel. Frame bytes arrive on a byte stream with a valid/ready handshake and an end-of-frame flag. Each byte accepted into a buffer is sent out again with its byte-granular destination address. A separate DMA path, outside this block, turns those addresses into memory writes.

Back-pressure on the frame stream follows two rules:
- The engine raises `rx_ready` only while it holds an owned descriptor with a usable buffer, or while it is discarding the rest of a rejected frame.
- While it fetches descriptors, writes back status or waits on a descriptor the host still owns, `rx_ready` stays low. The sender then keeps `rx_valid`, `rx_data` and `rx_last` unchanged.

On the memory side, a request stays stable until `mem_req_ready` accepts it. Only one read is outstanding at a time.

Top module: `rxd_ring_engine`

## Requirements
- R1: `base_err` is high whenever any of `cfg_base[3:0]` is nonzero. Descriptor addresses always use `cfg_base` with those four bits taken as zero.
- R2: Descriptor n occupies four words at base + 16*n. The buffer address is at +0, the buffer length at +4 (bits [15:0]), the status word at +8, and +12 is unused. For each descriptor, the engine reads +8, then +0, then +4.
- R3: The descriptor index advances by one after each release. It wraps to 0 after index `cfg_ring_len`-1. A length of 0 or 1 keeps the index at 0.
- R4: Status word layout: bit 31 is the owner flag (1 = engine owns it), bit 30 marks the first buffer of a frame, bit 29 the last buffer, bit 28 an error, and bits [15:0] the number of bytes stored in the buffer. All other bits are written as 0.
- R5: When the status read returns owner = 0, the engine keeps `rx_ready` low. It reads the same status word again `cfg_poll_gap` cycles after the response, and it never reads any other descriptor until it sees owner = 1.
- R6: A descriptor is released with two writes to its status word. The first carries all fields with owner = 1. The second repeats the same fields with owner = 0.
- R7: Each accepted byte of a usable buffer appears on `buf_wr_*` in the same cycle. Its address is the buffer address plus the byte's offset within that buffer.
- R8: If a buffer fills before the last byte of the frame, its descriptor is closed with the last-buffer flag at 0 and a count equal to the buffer length. The frame then continues in the next descriptor, with the first-buffer flag at 0. The descriptor that takes the final byte gets the last-buffer flag at 1 and the remaining byte count, including the case where the final byte exactly fills the buffer.
- R9: A buffer length is usable only if it is nonzero and is either a multiple of 4 or at least `MAX_FRAME`. Otherwise the remaining bytes of the frame are accepted and discarded with no `buf_wr_valid`, and the descriptor is released with the error and last-buffer flags set and a count of 0.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request address, direction and write data stay unchanged into the next cycle.
- R11: While `ring_en` is low, the engine issues no memory request, holds `rx_ready` low and returns to descriptor 0. After re-enabling, its first reads are to descriptor 0.
- R12: Under reset, `rx_ready`, `mem_req_valid` and `buf_wr_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ring_en | input | 1 | Ring enable. Low holds the engine idle at descriptor 0 |
| cfg_base | input | AW | Ring base address. The low 4 bits are ignored |
| cfg_ring_len | input | IW | Number of descriptors in the ring |
| cfg_poll_gap | input | PW | Cycles to wait before re-reading a host-owned status word |
| base_err | output | 1 | Base address is not 16-byte aligned |
| mem_req_valid | output | 1 | Descriptor memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| rx_valid | input | 1 | Frame byte valid |
| rx_ready | output | 1 | Engine accepts a frame byte |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last of its frame |
| buf_wr_valid | output | 1 | Byte write to a host buffer |
| buf_wr_addr | output | AW | Byte address of that write |
| buf_wr_data | output | 8 | Byte value |

## Verification
Two sweeps run every frame length from 1 up to two buffers plus one byte, once with 4-byte buffers and once with 8-byte buffers, over a four-descriptor ring. Short frames show single-buffer closure. Lengths that equal a multiple of the buffer size separate an exact fill from a spill into a new descriptor. The longer frames carry the index across the ring wrap. Length sets that mix an odd size below the limit, an odd size above the limit, and a bad buffer in the middle of a chain tell the two acceptance rules apart and show that a mid-frame rejection is handled. A ring whose second descriptor starts host-owned shows stalling and re-polling without look-ahead. The memory model withholds ready every fourth cycle, which exercises request holding.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_STAT_RQ, ST_STAT_RSP, ST_POLL,
    ST_ADDR_RQ, ST_ADDR_RSP, ST_LEN_RQ, ST_LEN_RSP,
    ST_RECV, ST_DROP, ST_WB_STAT, ST_WB_OWN
  } rxd_state_e;

  localparam int OWN_BIT = 31;
  localparam int SOF_BIT = 30;
  localparam int EOF_BIT = 29;
  localparam int ERR_BIT = 28;

  localparam logic [3:0] WORD_BUF  = 4'h0;
  localparam logic [3:0] WORD_LEN  = 4'h4;
  localparam logic [3:0] WORD_STAT = 4'h8;
endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  input  logic [AW-5:0] base_hi,
  input  logic [IW-1:0] ring_len,
  output logic [IW-1:0] idx,
  output logic [AW-1:0] entry_addr
);
  localparam int ENTRY_SHIFT = 4;

  logic at_end;
  assign at_end = (ring_len <= IW'(1)) || (idx == ring_len - IW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear)
      idx <= '0;
    else if (advance)
      idx <= at_end ? '0 : idx + IW'(1);
  end

  // each entry spans four 32-bit words
  assign entry_addr = {base_hi, {ENTRY_SHIFT{1'b0}}} + (AW'(idx) << ENTRY_SHIFT);
endmodule

// File: rtl/rxd_len_rule.sv
module rxd_len_rule #(
  parameter int LW        = 16,
  parameter int MAX_FRAME = 1518
) (
  input  logic [LW-1:0] len,
  output logic          ok
);
  localparam logic [LW-1:0] MAX_L = LW'(MAX_FRAME);

  assign ok = (len != '0) && ((len[1:0] == 2'b00) || (len >= MAX_L));
endmodule

// File: rtl/rxd_poll_timer.sv
module rxd_poll_timer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] gap,
  output logic          done
);
  logic [PW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)
      remain <= '0;
    else if (load)
      remain <= gap;
    else if (remain != '0)
      remain <= remain - PW'(1);
  end

  assign done = (remain == '0) && !load;
endmodule

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine
  import rxd_pkg::*;
#(
  parameter int AW        = 32,
  parameter int IW        = 16,
  parameter int LW        = 16,
  parameter int MAX_FRAME = 1518,
  parameter int PW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ring_en,
  input  logic [AW-1:0] cfg_base,
  input  logic [IW-1:0] cfg_ring_len,
  input  logic [PW-1:0] cfg_poll_gap,
  output logic          base_err,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  output logic          buf_wr_valid,
  output logic [AW-1:0] buf_wr_addr,
  output logic [7:0]    buf_wr_data
);
  rxd_state_e    state;
  logic [AW-1:0] buf_addr;
  logic [LW-1:0] buf_len;
  logic [LW-1:0] fill;
  logic          sof_q, eof_q, err_q;

  logic [IW-1:0] idx;
  logic [AW-1:0] entry_addr;
  logic          req_fire, rx_fire, advance, len_ok, poll_load, poll_done;
  logic [3:0]    word_ofs;
  logic          buf_full;

  assign base_err = |cfg_base[3:0];
  assign req_fire = mem_req_valid && mem_req_ready;
  assign rx_fire  = rx_valid && rx_ready;
  assign advance  = (state == ST_WB_OWN) && req_fire;
  assign poll_load = (state == ST_STAT_RSP) && mem_rsp_valid && !mem_rsp_data[OWN_BIT];
  assign buf_full = ({1'b0, fill} + {{LW{1'b0}}, 1'b1}) == {1'b0, buf_len};

  rxd_ring_ptr #(.AW(AW), .IW(IW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clear(!ring_en), .advance(advance),
    .base_hi(cfg_base[AW-1:4]), .ring_len(cfg_ring_len),
    .idx(idx), .entry_addr(entry_addr)
  );

  rxd_len_rule #(.LW(LW), .MAX_FRAME(MAX_FRAME)) u_len (
    .len(mem_rsp_data[LW-1:0]), .ok(len_ok)
  );

  rxd_poll_timer #(.PW(PW)) u_poll (
    .clk(clk), .rst_n(rst_n), .load(poll_load), .gap(cfg_poll_gap), .done(poll_done)
  );

  // request channel decode
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    word_ofs      = WORD_STAT;
    unique case (state)
      ST_STAT_RQ: mem_req_valid = 1'b1;
      ST_ADDR_RQ: begin mem_req_valid = 1'b1; word_ofs = WORD_BUF; end
      ST_LEN_RQ:  begin mem_req_valid = 1'b1; word_ofs = WORD_LEN; end
      ST_WB_STAT, ST_WB_OWN: begin mem_req_valid = 1'b1; mem_req_we = 1'b1; end
      default: ;
    endcase
  end

  assign mem_req_addr = entry_addr + AW'(word_ofs);

  always_comb begin
    mem_req_wdata          = '0;
    mem_req_wdata[LW-1:0]  = fill;
    mem_req_wdata[OWN_BIT] = (state == ST_WB_STAT);
    mem_req_wdata[SOF_BIT] = sof_q;
    mem_req_wdata[EOF_BIT] = eof_q;
    mem_req_wdata[ERR_BIT] = err_q;
  end

  assign rx_ready     = (state == ST_RECV) || (state == ST_DROP);
  assign buf_wr_valid = rx_fire && (state == ST_RECV);
  assign buf_wr_addr  = buf_addr + AW'(fill);
  assign buf_wr_data  = rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n || !ring_en) begin
      state    <= ST_IDLE;
      buf_addr <= '0;
      buf_len  <= '0;
      fill     <= '0;
      sof_q    <= 1'b1;
      eof_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:     state <= ST_STAT_RQ;
        ST_STAT_RQ:  if (req_fire) state <= ST_STAT_RSP;
        ST_STAT_RSP: if (mem_rsp_valid)
                       state <= mem_rsp_data[OWN_BIT] ? ST_ADDR_RQ : ST_POLL;
        ST_POLL:     if (poll_done) state <= ST_STAT_RQ;
        ST_ADDR_RQ:  if (req_fire) state <= ST_ADDR_RSP;
        ST_ADDR_RSP: if (mem_rsp_valid) begin
                       buf_addr <= AW'(mem_rsp_data);
                       state    <= ST_LEN_RQ;
                     end
        ST_LEN_RQ:   if (req_fire) state <= ST_LEN_RSP;
        ST_LEN_RSP:  if (mem_rsp_valid) begin
                       buf_len <= mem_rsp_data[LW-1:0];
                       fill    <= '0;
                       eof_q   <= 1'b0;
                       if (len_ok) state <= ST_RECV;
                       else begin
                         err_q <= 1'b1;
                         state <= ST_DROP;
                       end
                     end
        ST_RECV:     if (rx_fire) begin
                       fill <= fill + LW'(1);
                       if (rx_last) begin
                         eof_q <= 1'b1;
                         state <= ST_WB_STAT;
                       end else if (buf_full) begin
                         state <= ST_WB_STAT;
                       end
                     end
        ST_DROP:     if (rx_fire && rx_last) begin
                       eof_q <= 1'b1;
                       state <= ST_WB_STAT;
                     end
        ST_WB_STAT:  if (req_fire) state <= ST_WB_OWN;
        ST_WB_OWN:   if (req_fire) begin
                       sof_q <= eof_q;
                       err_q <= 1'b0;
                       state <= ST_STAT_RQ;
                     end
        default:     state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxd_ring_chk.sv
module rxd_ring_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ring_en,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [31:0]   mem_req_wdata,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          buf_wr_valid
);
  logic          prev_set;
  logic [AW-1:0] prev_addr;
  logic [30:0]   prev_fields;
  logic          wr_fire;

  assign wr_fire = mem_req_valid && mem_req_ready && mem_req_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_set    <= 1'b0;
      prev_addr   <= '0;
      prev_fields <= '0;
    end else if (wr_fire) begin
      prev_set    <= mem_req_wdata[31];
      prev_addr   <= mem_req_addr;
      prev_fields <= mem_req_wdata[30:0];
    end
  end

  // R2
  word_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[3:0] == 4'h0 || mem_req_addr[3:0] == 4'h4 ||
                       mem_req_addr[3:0] == 4'h8));

  // R6
  own_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !mem_req_wdata[31]) |->
      (prev_set && prev_addr == mem_req_addr && prev_fields == mem_req_wdata[30:0]));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  // R11
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_en |=> (!mem_req_valid && !rx_ready));

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !mem_req_valid);

  // R9
  err_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we && mem_req_wdata[28]) |-> (mem_req_wdata[15:0] == 16'h0));

  // R7
  byte_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_valid |-> (rx_valid && rx_ready));
endmodule

bind rxd_ring_engine rxd_ring_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_en(ring_en),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .buf_wr_valid(buf_wr_valid)
);

// File: tb/tb_rxd_ring_engine.sv
module tb_rxd_ring_engine;
  localparam int RL = 4;
  localparam int MAXF = 10;
  localparam logic [31:0] RBASE = 32'h40;
  localparam int LOGN = 1024;

  logic clk = 1'b0, rst_n = 1'b0, ring_en = 1'b0;
  logic [31:0] cfg_base = 32'h45;
  logic [15:0] cfg_ring_len = 16'(RL);
  logic [7:0]  cfg_poll_gap = 8'd3;
  logic base_err, mem_req_valid, mem_req_we, rx_ready, buf_wr_valid;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata, buf_wr_addr;
  logic [31:0] mem_rsp_data = '0;
  logic rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_data = '0, buf_wr_data;

  always #10 clk = ~clk;

  rxd_ring_engine #(.AW(32), .IW(16), .LW(16), .MAX_FRAME(MAXF), .PW(8)) dut (
    .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .cfg_base(cfg_base),
    .cfg_ring_len(cfg_ring_len), .cfg_poll_gap(cfg_poll_gap), .base_err(base_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .buf_wr_valid(buf_wr_valid), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data)
  );

  // memory model and logs
  logic [31:0] mem [0:63];
  logic [31:0] wlog_a [0:LOGN-1], wlog_d [0:LOGN-1], rlog_a [0:LOGN-1];
  logic [31:0] blog_a [0:LOGN-1];
  logic [7:0]  blog_d [0:LOGN-1];
  int wcount = 0, rcount = 0, bcount = 0, hold_bad = 0;
  logic [3:0] rdy_ctr = '0;
  logic hold_pend = 1'b0, held_we = 1'b0;
  logic [31:0] held_addr = '0;
  logic host_we = 1'b0;
  logic [31:0] host_addr = '0, host_wdata = '0;

  always @(posedge clk) begin
    rdy_ctr <= rdy_ctr + 4'd1;
    mem_req_ready <= rst_n && (rdy_ctr[1:0] != 2'b11);
    mem_rsp_valid <= 1'b0;
    if (hold_pend && (!mem_req_valid || mem_req_addr != held_addr || mem_req_we != held_we))
      hold_bad <= hold_bad + 1;
    hold_pend <= rst_n && mem_req_valid && !mem_req_ready;
    held_addr <= mem_req_addr;
    held_we   <= mem_req_we;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr[7:2]] <= mem_req_wdata;
        if (wcount < LOGN) begin
          wlog_a[wcount] <= mem_req_addr;
          wlog_d[wcount] <= mem_req_wdata;
        end
        wcount <= wcount + 1;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[7:2]];
        if (rcount < LOGN) rlog_a[rcount] <= mem_req_addr;
        rcount <= rcount + 1;
      end
    end
    if (host_we) mem[host_addr[7:2]] <= host_wdata;
    if (buf_wr_valid) begin
      if (bcount < LOGN) begin
        blog_a[bcount] <= buf_wr_addr;
        blog_d[bcount] <= buf_wr_data;
      end
      bcount <= bcount + 1;
    end
  end

  int n_chk = 0, n_bad = 0;
  int d_len [0:RL-1];
  int exp_idx = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] buf_base(input int i);
    return 32'h1000 + 32'h100 * i + 32'(i) + 32'h1;
  endfunction

  function automatic bit len_usable(input int l);
    return (l != 0) && ((l % 4 == 0) || (l >= MAXF));
  endfunction

  task automatic host_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic setup_ring(input int l0, l1, l2, l3, input logic [3:0] own);
    int r0;
    int t;
    ring_en = 1'b0;
    repeat (3) @(negedge clk);
    d_len[0] = l0; d_len[1] = l1; d_len[2] = l2; d_len[3] = l3;
    for (int i = 0; i < RL; i++) begin
      host_write(RBASE + 32'(16 * i), buf_base(i));
      host_write(RBASE + 32'(16 * i) + 32'h4, 32'(d_len[i]));
      host_write(RBASE + 32'(16 * i) + 32'h8, own[i] ? 32'h8000_0000 : 32'h0);
    end
    exp_idx = 0;
    r0 = rcount;
    @(negedge clk);
    ring_en = 1'b1;
    t = 0;
    while (rcount < r0 + 3 && t < 200) begin @(negedge clk); t++; end
    // R11 restart at entry 0; R2 word order status, address, length
    check(rlog_a[r0] == RBASE + 32'h8, "R11 first read", rlog_a[r0], RBASE + 32'h8);
    check(rlog_a[r0 + 1] == RBASE && rlog_a[r0 + 2] == RBASE + 32'h4, "R2 read order",
          rlog_a[r0 + 2], RBASE + 32'h4);
  endtask

  task automatic send_frame(input int len, input int tag);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = 8'(tag * 16 + i);
      rx_last  = (i == len - 1);
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
  endtask

  task automatic do_frame(input int len, input int tag);
    int w0, b0, rem, pos, idx, nrel, nbytes, t;
    bit first;
    int r_idx [0:15];
    logic [31:0] r_stat [0:15];
    logic [31:0] e_ba [0:63];
    logic [7:0]  e_bd [0:63];
    w0 = wcount; b0 = bcount;
    rem = len; pos = 0; idx = exp_idx; nrel = 0; nbytes = 0; first = 1'b1;
    while (1) begin
      int take;
      bit last;
      if (!len_usable(d_len[idx])) begin
        r_idx[nrel] = idx;
        r_stat[nrel] = {1'b1, first, 1'b1, 1'b1, 28'h0};
        nrel++;
        idx = (idx + 1) % RL;
        break;
      end
      last = (rem <= d_len[idx]);
      take = last ? rem : d_len[idx];
      for (int j = 0; j < take; j++) begin
        e_ba[nbytes] = buf_base(idx) + 32'(j);
        e_bd[nbytes] = 8'(tag * 16 + pos + j);
        nbytes++;
      end
      r_idx[nrel] = idx;
      r_stat[nrel] = {1'b1, first, last, 1'b0, 12'h0, 16'(take)};
      nrel++;
      pos += take; rem -= take;
      idx = (idx + 1) % RL;
      first = 1'b0;
      if (last) break;
    end
    send_frame(len, tag);
    t = 0;
    while (wcount < w0 + 2 * nrel && t < 500) begin @(negedge clk); t++; end
    check(wcount == w0 + 2 * nrel, "R6 write count", wcount - w0, 2 * nrel);
    for (int r = 0; r < nrel; r++) begin
      logic [31:0] ea;
      ea = RBASE + 32'(16 * r_idx[r]) + 32'h8;
      // R3 ring position, R4 field layout, R8 chaining flags and counts
      check(wlog_a[w0 + 2 * r] == ea && wlog_a[w0 + 2 * r + 1] == ea, "R3 release address",
            wlog_a[w0 + 2 * r + 1], ea);
      check(wlog_d[w0 + 2 * r] == r_stat[r], "R4 R8 status with owner set",
            wlog_d[w0 + 2 * r], r_stat[r]);
      check(wlog_d[w0 + 2 * r + 1] == {1'b0, r_stat[r][30:0]}, "R6 owner cleared last",
            wlog_d[w0 + 2 * r + 1], {1'b0, r_stat[r][30:0]});
    end
    check(bcount - b0 == nbytes, "R7 R9 byte write count", bcount - b0, nbytes);
    for (int k = 0; k < nbytes && b0 + k < bcount; k++)
      check(blog_a[b0 + k] == e_ba[k] && blog_d[b0 + k] == e_bd[k], "R7 byte address",
            blog_a[b0 + k], e_ba[k]);
    for (int r = 0; r < nrel; r++)
      host_write(RBASE + 32'(16 * r_idx[r]) + 32'h8, 32'h8000_0000);
    exp_idx = idx;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12 reset state
    check(!rx_ready && !mem_req_valid && !buf_wr_valid, "R12 reset outputs",
          {rx_ready, mem_req_valid, buf_wr_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!rx_ready && !mem_req_valid, "R11 disabled idle", {rx_ready, mem_req_valid}, 0);
    // R1 misaligned base flagged, low bits dropped from addresses
    check(base_err == 1'b1, "R1 base error flag", base_err, 1);

    for (int bl = 4; bl <= 8; bl += 4) begin
      setup_ring(bl, bl, bl, bl, 4'hF);
      for (int l = 1; l <= 2 * bl + 1; l++) do_frame(l, l);
    end

    // R9 unusable odd length, usable odd length at or above the limit
    setup_ring(6, 11, 4, 4, 4'hF);
    do_frame(5, 2);
    do_frame(7, 3);
    do_frame(6, 4);
    // R9 rejection in the middle of a chain
    setup_ring(4, 6, 4, 4, 4'hF);
    do_frame(6, 5);
    do_frame(3, 6);

    // R5 stall on a host-owned entry
    setup_ring(4, 4, 4, 4, 4'b1101);
    do_frame(4, 7);
    begin
      int r0;
      bit rdy_seen;
      bit other;
      r0 = rcount;
      rdy_seen = 1'b0;
      other = 1'b0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (rx_ready) rdy_seen = 1'b1;
      end
      for (int k = r0; k < rcount; k++)
        if (rlog_a[k] != RBASE + 32'h18) other = 1'b1;
      check(!rdy_seen, "R5 ready low while stalled", rdy_seen, 0);
      check(rcount - r0 >= 2, "R5 status re-polled", rcount - r0, 2);
      check(!other, "R5 no look-ahead", other, 0);
    end
    host_write(RBASE + 32'h18, 32'h8000_0000);
    do_frame(3, 8);

    cfg_base = RBASE;
    @(negedge clk);
    check(base_err == 1'b0, "R1 aligned base", base_err, 0);
    check(hold_bad == 0, "R10 request held", hold_bad, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule